// File: doc/BRIEF.md
# Read/Write Bus Buffer with Write Queue and Read Latch

This block couples a fast bus (side A) to a slower one (side B) across an 18-bit data path in each direction. Words headed from A to B pass through a four-word first-in first-out queue. A single clock runs the queue, and two active-low enables qualify each edge: one stores the A word, the other advances the next stored word into a registered B output. An active-low flag shows when the queue cannot take more. A synchronous active-low reset empties the queue and drives the B output to all ones.

Words headed from B to A pass through a transparent latch. While the latch enable is high, A follows B directly. When the enable falls, the B value is captured and held. Each side has its own active-low drive enable. The bidirectional pads are modelled as separate in, out and output-enable signals.

The enables and the full flag are the block's defined control pins, so no valid/ready handshake is added. Back-pressure is given by the full flag: while it is low, a write request is dropped. A consumer that reads an empty queue simply sees the last word again.

Top module: `rw_bus_buffer`

## Requirements
- R1: The queue holds up to DEPTH (default 4) words of W (default 18) bits. Words leave on `b_out` in the order they were written.
- R2: A write request (`wr_en_n` low at a rising edge) while four words are held is dropped. The stored words and the flag are unchanged.
- R3: A read request (`rd_en_n` low) while the queue is empty has no effect. `b_out` keeps the last word it showed.
- R4: With both requests in one edge, both take effect when the queue is neither empty nor full. When it is empty only the write happens, and when it is full only the read happens.
- R5: `full_n` is 0 exactly when four words are held and 1 otherwise, including directly after reset.
- R6: A rising edge with `rst_n` low empties the queue and sets `b_out` to all ones. This overrides any read or write requested at that edge.
- R7: `b_out` changes only at a rising edge that accepts a read, or at a reset edge.
- R8: While `lat_en` is 1, `a_out` equals `b_in`. After `lat_en` falls, `a_out` holds the value captured at the fall, whatever `b_in` does.
- R9: `a_oe` is 1 exactly when `a_drive_n` is 0, and `b_oe` is 1 exactly when `b_drive_n` is 0.
- R10: Queue behaviour does not depend on `lat_en` or on the latch contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Queue clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_n | input | 1 | Write request, active low |
| rd_en_n | input | 1 | Read request, active low |
| full_n | output | 1 | Queue full flag, active low |
| a_in | input | 18 | Word arriving from side A pads |
| a_out | output | 18 | Word driven onto side A pads |
| a_oe | output | 1 | Side A pad drive enable |
| a_drive_n | input | 1 | Side A drive request, active low |
| b_in | input | 18 | Word arriving from side B pads |
| b_out | output | 18 | Word driven onto side B pads |
| b_oe | output | 1 | Side B pad drive enable |
| b_drive_n | input | 1 | Side B drive request, active low |
| lat_en | input | 1 | Read latch enable, high is transparent |

## Verification
The queue is filled to four words with distinct patterns and then drained in order, which separates correct ordering from pointer wrap errors. Extra writes at full and reads at empty show that dropped requests leave both the flag and `b_out` alone. Paired read-and-write edges are applied at the empty, middle and full levels, which separates the three resolution rules. Reset is applied with requests pending to show that it takes priority. The latch is opened, closed and then disturbed on `b_in` during queue traffic, which shows that the hold works and that the two paths are independent.

// File: rtl/rwbuf_pkg.sv
package rwbuf_pkg;
  parameter int unsigned RWB_WIDTH = 18;
  parameter int unsigned RWB_DEPTH = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_PUSH  = 2'b10,
    OP_POP   = 2'b01,
    OP_BOTH  = 2'b11
  } q_op_e;
endpackage

// File: rtl/wq_fifo.sv
module wq_fifo #(
  parameter int unsigned W     = rwbuf_pkg::RWB_WIDTH,
  parameter int unsigned DEPTH = rwbuf_pkg::RWB_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_n,
  input  logic         rd_en_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full_n
);
  import rwbuf_pkg::*;

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          is_full, is_empty, push, pop;
  q_op_e         op;

  assign is_full  = (count == FULLC);
  assign is_empty = (count == '0);
  assign push     = !wr_en_n && !is_full;
  assign pop      = !rd_en_n && !is_empty;
  assign op       = q_op_e'({push, pop});
  assign full_n   = !is_full;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dout  <= '1;
    end else begin
      if (push) begin
        mem[wptr] <= din;
        wptr      <= step_ptr(wptr);
      end
      if (pop) begin
        dout <= mem[rptr];
        rptr <= step_ptr(rptr);
      end
      case (op)
        OP_PUSH: count <= count + CW'(1);
        OP_POP:  count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R6
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (full_n && dout == '1));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && rd_en_n) |=> (!full_n && $stable(dout)));

  // R3
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && !rd_en_n) |=> $stable(dout));

  // R7
  out_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |=> $stable(dout));

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);

  // R4
  full_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && !rd_en_n) |=> full_n);
endmodule

// File: rtl/rd_latch.sv
module rd_latch #(
  parameter int unsigned W = rwbuf_pkg::RWB_WIDTH
) (
  input  logic         le,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] held;

  always_latch begin
    if (le) held = din;
  end

  assign dout = held;
endmodule

// File: rtl/pad_drive.sv
module pad_drive #(
  parameter int unsigned W = rwbuf_pkg::RWB_WIDTH
) (
  input  logic         drive_n,
  input  logic [W-1:0] data,
  output logic [W-1:0] pad_out,
  output logic         pad_oe
);
  assign pad_out = data;
  assign pad_oe  = !drive_n;
endmodule

// File: rtl/rw_bus_buffer.sv
module rw_bus_buffer #(
  parameter int unsigned W     = rwbuf_pkg::RWB_WIDTH,
  parameter int unsigned DEPTH = rwbuf_pkg::RWB_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_n,
  input  logic         rd_en_n,
  output logic         full_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic         a_drive_n,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         b_drive_n,
  input  logic         lat_en
);
  logic [W-1:0] q_word, l_word;

  wq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .din(a_in), .dout(q_word), .full_n(full_n)
  );

  rd_latch #(.W(W)) u_latch (
    .le(lat_en), .din(b_in), .dout(l_word)
  );

  pad_drive #(.W(W)) u_bdrv (
    .drive_n(b_drive_n), .data(q_word), .pad_out(b_out), .pad_oe(b_oe)
  );

  pad_drive #(.W(W)) u_adrv (
    .drive_n(a_drive_n), .data(l_word), .pad_out(a_out), .pad_oe(a_oe)
  );
endmodule

// File: tb/sim_rw_bus_buffer.sv
`timescale 1ns/1ps
module sim_rw_bus_buffer;
  localparam int W = 18;
  localparam int DEPTH = 4;

  logic clk = 0;
  logic rst_n = 0, wr_en_n = 1, rd_en_n = 1, a_drive_n = 1, b_drive_n = 1, lat_en = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic full_n, a_oe, b_oe;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] sb [$];
  logic [W-1:0] exp_b = '1;

  always #2.5 clk = ~clk;

  rw_bus_buffer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .full_n(full_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .a_drive_n(a_drive_n), .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .b_drive_n(b_drive_n), .lat_en(lat_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: predicts, pushes expectations, applies one edge; monitor compare follows
  task automatic cyc(input bit w, input logic [W-1:0] d, input bit r, input string tag);
    bit wacc, racc;
    wacc = w && (sb.size() < DEPTH);
    racc = r && (sb.size() > 0);
    if (racc) exp_b = sb.pop_front();
    if (wacc) sb.push_back(d);
    wr_en_n = !w; rd_en_n = !r; a_in = d;
    @(posedge clk); #1;
    wr_en_n = 1; rd_en_n = 1;
    chk(b_out == exp_b, {tag, " b_out"}, b_out, exp_b);
    chk(full_n == (sb.size() != DEPTH), {tag, " full_n R5"}, W'(full_n), W'(sb.size() != DEPTH));
  endtask

  task automatic do_reset(input bit w, input bit r);
    rst_n = 0; wr_en_n = !w; rd_en_n = !r; a_in = 18'h2AAAA;
    @(posedge clk); #1;
    rst_n = 1; wr_en_n = 1; rd_en_n = 1;
    sb.delete(); exp_b = '1;
    chk(b_out == '1, "R6 reset b_out ones", b_out, '1);
    chk(full_n == 1'b1, "R6 reset full_n high", W'(full_n), W'(1));
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    do_reset(0, 0);
    // R3 read of empty queue
    cyc(0, '0, 1, "R3 empty read");
    // R1 fill with distinct patterns, R5 flag at four
    cyc(1, 18'h00001, 0, "R1 w1");
    cyc(1, 18'h3FFFE, 0, "R1 w2");
    cyc(1, 18'h15555, 0, "R1 w3");
    cyc(1, 18'h2AAAA, 0, "R1 w4 R5");
    // R2 overflow dropped
    cyc(1, 18'h12345, 0, "R2 full write");
    // R4 pair at full: read only
    cyc(1, 18'h0BEEF, 1, "R4 pair full");
    // R4 pair in middle: both
    cyc(1, 18'h0CAFE, 1, "R4 pair mid");
    // R10 toggle latch during drain
    lat_en = 1; b_in = 18'h11111;
    cyc(0, '0, 1, "R10 drain a");
    lat_en = 0; b_in = 18'h22222;
    cyc(0, '0, 1, "R1 drain b");
    cyc(0, '0, 1, "R1 drain c");
    // R3 empty again: hold last
    cyc(0, '0, 1, "R3 empty hold");
    // R4 pair at empty: write only
    cyc(1, 18'h31337, 1, "R4 pair empty");
    cyc(0, '0, 1, "R4 read after pair");
    // R7 idle edges keep output
    cyc(1, 18'h00F0F, 0, "R7 write only");
    cyc(0, '0, 0, "R7 idle");
    // R6 reset with requests pending takes priority
    do_reset(1, 1);
    cyc(0, '0, 1, "R6 empty after reset");
    // R8 latch transparent then hold
    lat_en = 1; b_in = 18'h0A5A5; #1;
    chk(a_out == 18'h0A5A5, "R8 transparent", a_out, 18'h0A5A5);
    b_in = 18'h1C3C3; #1;
    chk(a_out == 18'h1C3C3, "R8 follows", a_out, 18'h1C3C3);
    lat_en = 0; #1; b_in = 18'h00007; #1;
    chk(a_out == 18'h1C3C3, "R8 hold after fall", a_out, 18'h1C3C3);
    // R9 drive enables
    a_drive_n = 0; b_drive_n = 1; #1;
    chk(a_oe == 1 && b_oe == 0, "R9 A on B off", W'({a_oe, b_oe}), W'(2'b10));
    a_drive_n = 1; b_drive_n = 0; #1;
    chk(a_oe == 0 && b_oe == 1, "R9 A off B on", W'({a_oe, b_oe}), W'(2'b01));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule